// File: doc/BRIEF.md
# Capability Record List Walker

The walker reads a chain of self-describing capability records out of a word-addressed configuration memory and turns the records it knows into registered capability values. A one-cycle `start` pulse with a base word address begins a walk. The block fetches 32-bit words through a synchronous read port, one word per request. It examines each record header, pulls in value words where it needs them, and jumps over the rest until an end marker, an error or an empty list finishes the walk.

Each record is a header word followed by its value words. Bit 31 of the header is the mandatory flag. Bits 30:16 hold the record kind, and bits 15:0 give the value length in bytes. That length does not count the header and must be a multiple of four. The next header sits directly after the last value word. The walker produces five results: a clock frequency word, a mailbox area (byte offset and byte length), a representor capability word, a statistics area (byte offset and entry count), and the number of records it accepted. The `done` and `err` flags stay set until the next accepted start. `err_code` tells apart the ways a walk can fail.

Top module: `caprec_walker`

## Requirements
- R1: A `start` pulse while idle drives `rd_en` high with `rd_addr` equal to `base_addr` in the same cycle, and raises `busy` on the next edge. Read data is taken one cycle after each request, and `busy` stays high until `done` rises.
- R2: If the first word read is all zeros, the walk ends with `done`=1, `err`=0 and `rec_count`=0. Every accepted start restores the defaults: frequency 0, representor word 0, mailbox offset 0x1800 and length 0x1F8, statistics offset 0 and count 0.
- R3: A record of kind 2 ends the walk with `done`=1 and `err`=0, and is counted in `rec_count`. An end record placed in the last memory word is legal.
- R4: A record of kind 0 (with a non-zero header word) aborts the walk with `err`=1 and `err_code`=1. `rec_count` then holds the number of records accepted before it.
- R5: A record of an unrecognised kind with bit 31 set aborts with `err_code`=2. One without bit 31 is skipped. Bit 31 on a recognised kind changes nothing.
- R6: A record of kind 1 is padding. Its value words are skipped unread, and a zero-length padding record is accepted.
- R7: For kind 3 with length at least 4, the first value word is latched as the frequency. For kind 7, it is latched as the representor capability word.
- R8: A record of kind 4 sets the mailbox offset to the byte address of its first value word (4 × (header word address + 1)) and the mailbox length to its length field.
- R9: A record of kind 12 sets the statistics offset to the byte address of its first value word and the statistics count to floor(length / 10).
- R10: A length field that is not a multiple of 4 aborts with `err_code`=3.
- R11: A record whose value runs past the last memory word, or a non-end record that leaves no word for a following header, aborts with `err_code`=4. `rd_addr` never exceeds the last word while `rd_en` is high. The checks apply in this priority: kind 0, then length alignment, then memory bound, then unknown mandatory.
- R12: A `start` pulse while `busy` is high is ignored. The walk in progress finishes with the same results it would have had without the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Walk request pulse |
| base_addr | input | ADDR_W | Word address of the first record header |
| rd_en | output | 1 | Memory read request |
| rd_addr | output | ADDR_W | Word address of the read |
| rd_data | input | 32 | Read data, valid the cycle after `rd_en` |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk finished (held until the next accepted start) |
| err | output | 1 | Walk finished with an error |
| err_code | output | 3 | 0 none, 1 kind 0, 2 unknown mandatory, 3 misaligned length, 4 memory bound |
| freq_mhz | output | 32 | Latched clock frequency word |
| mbox_off | output | 16 | Mailbox area byte offset |
| mbox_len | output | 16 | Mailbox area byte length |
| repr_cap | output | 32 | Representor capability word |
| stats_off | output | 16 | Statistics area byte offset |
| stats_cnt | output | 16 | Number of statistics entries |
| rec_count | output | ADDR_W+1 | Records accepted in the last walk |

## Verification
The embedded properties watch rules that hold every cycle. Read addresses stay inside the memory. `done` is only ever set while idle. An error always coincides with the end of a walk. During a walk the record count moves by at most one per cycle, so a stray start cannot reset it. The mailbox area holds unless a mailbox record or a new walk loads it. Capability values, byte offsets, the floor division of the statistics length, the error code of each failure, and the exact memory boundary cases depend on the list contents. Only the bench's directed lists, with known expected results, can show these.

// File: rtl/caprec_pkg.sv
// Shared types for the capability record walker.
// Assumes: record kinds occupy 15 bits and lengths 16 bits of a header word.
package caprec_pkg;

    typedef enum logic [2:0] {
        ERR_NONE        = 3'd0,
        ERR_BAD_TYPE    = 3'd1,
        ERR_REQ_UNKNOWN = 3'd2,
        ERR_MISALIGN    = 3'd3,
        ERR_OVERRUN     = 3'd4
    } walk_err_e;

    typedef enum logic [2:0] {
        ACT_SKIP,
        ACT_END,
        ACT_FAIL,
        ACT_FREQ,
        ACT_REPR,
        ACT_MBOX,
        ACT_STATS
    } rec_act_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HDR,
        ST_VAL
    } walk_state_e;

    localparam logic [14:0] KIND_INVALID = 15'd0;
    localparam logic [14:0] KIND_PAD     = 15'd1;
    localparam logic [14:0] KIND_END     = 15'd2;
    localparam logic [14:0] KIND_FREQ    = 15'd3;
    localparam logic [14:0] KIND_MBOX    = 15'd4;
    localparam logic [14:0] KIND_REPR    = 15'd7;
    localparam logic [14:0] KIND_STATS   = 15'd12;

    typedef struct packed {
        logic        mandatory;
        logic [14:0] kind;
        logic [15:0] len;
    } rec_hdr_t;

endpackage

// File: rtl/caprec_hdr_decode.sv
// Combinational decode of one record header.
// Works out the action, the error class, the first value word address,
// the next header address and the statistics count.
// Assumes: hdr_addr < MEM_WORDS; outputs are only meaningful for a header word.
module caprec_hdr_decode
    import caprec_pkg::*;
#(
    parameter int MEM_WORDS = 1024,
    parameter int ADDR_W    = 10
) (
    input  logic [31:0]       hdr_word,
    input  logic [ADDR_W-1:0] hdr_addr,
    output rec_act_e          act,
    output walk_err_e         fail_code,
    output logic [ADDR_W-1:0] val_addr,
    output logic [ADDR_W-1:0] next_addr,
    output logic [15:0]       val_len,
    output logic [15:0]       stat_cnt
);
    localparam int EXT_W = ADDR_W + 15;
    localparam logic [EXT_W-1:0] LIMIT = EXT_W'(MEM_WORDS);

    rec_hdr_t         h;
    logic [EXT_W-1:0] last_ext;
    logic [EXT_W-1:0] next_ext;
    logic             overrun;

    assign h = rec_hdr_t'(hdr_word);

    // Address of the last value word and of the following header, with carry room.
    assign last_ext  = EXT_W'(hdr_addr) + EXT_W'(h.len[15:2]);
    assign next_ext  = last_ext + EXT_W'(1);
    assign overrun   = (last_ext >= LIMIT) || ((h.kind != KIND_END) && (next_ext >= LIMIT));

    assign val_addr  = hdr_addr + ADDR_W'(1);
    assign next_addr = next_ext[ADDR_W-1:0];
    assign val_len   = h.len;
    assign stat_cnt  = h.len / 16'd10;

    // Prioritised classification of the header.
    always_comb begin
        act       = ACT_SKIP;
        fail_code = ERR_NONE;
        if (h.kind == KIND_INVALID) begin
            act       = ACT_FAIL;
            fail_code = ERR_BAD_TYPE;
        end else if (h.len[1:0] != 2'b00) begin
            act       = ACT_FAIL;
            fail_code = ERR_MISALIGN;
        end else if (overrun) begin
            act       = ACT_FAIL;
            fail_code = ERR_OVERRUN;
        end else begin
            case (h.kind)
                KIND_END:   act = ACT_END;
                KIND_PAD:   act = ACT_SKIP;
                KIND_FREQ:  act = (h.len != 16'd0) ? ACT_FREQ : ACT_SKIP;
                KIND_REPR:  act = (h.len != 16'd0) ? ACT_REPR : ACT_SKIP;
                KIND_MBOX:  act = ACT_MBOX;
                KIND_STATS: act = ACT_STATS;
                default: begin
                    if (h.mandatory) begin
                        act       = ACT_FAIL;
                        fail_code = ERR_REQ_UNKNOWN;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/caprec_cap_bank.sv
// Registered capability values extracted by a walk.
// Loads each value on its strobe and returns all to defaults on clear.
// Assumes: clear is never raised together with a load strobe.
module caprec_cap_bank #(
    parameter logic [15:0] MBOX_DEF_OFF = 16'h1800,
    parameter logic [15:0] MBOX_DEF_LEN = 16'h01F8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        ld_freq,
    input  logic        ld_repr,
    input  logic        ld_mbox,
    input  logic        ld_stats,
    input  logic [31:0] val_word,
    input  logic [15:0] area_off,
    input  logic [15:0] area_len,
    input  logic [15:0] area_cnt,
    output logic [31:0] freq_mhz,
    output logic [31:0] repr_cap,
    output logic [15:0] mbox_off,
    output logic [15:0] mbox_len,
    output logic [15:0] stats_off,
    output logic [15:0] stats_cnt
);
    // Capability register updates.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            freq_mhz  <= '0;
            repr_cap  <= '0;
            mbox_off  <= MBOX_DEF_OFF;
            mbox_len  <= MBOX_DEF_LEN;
            stats_off <= '0;
            stats_cnt <= '0;
        end else begin
            if (ld_freq)  freq_mhz <= val_word;
            if (ld_repr)  repr_cap <= val_word;
            if (ld_mbox) begin
                mbox_off <= area_off;
                mbox_len <= area_len;
            end
            if (ld_stats) begin
                stats_off <= area_off;
                stats_cnt <= area_cnt;
            end
        end
    end

    AST_MBOX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !ld_mbox) |=> ($stable(mbox_off) && $stable(mbox_len))); // R8

    AST_CLEAR_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (mbox_off == MBOX_DEF_OFF && mbox_len == MBOX_DEF_LEN &&
                   freq_mhz == 32'd0 && stats_cnt == 16'd0)); // R2

endmodule

// File: rtl/caprec_walk_ctrl.sv
// Walk sequencer.
// Issues header and value reads, follows the decoder's verdict, and keeps
// the done/error flags and the record count.
// Assumes: rd_data is valid exactly one cycle after a read request.
module caprec_walk_ctrl
    import caprec_pkg::*;
#(
    parameter int MEM_WORDS = 1024,
    parameter int ADDR_W    = 10,
    parameter int CNT_W     = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [31:0]       rd_data,
    input  rec_act_e          act,
    input  walk_err_e         fail_code,
    input  logic [ADDR_W-1:0] val_addr,
    input  logic [ADDR_W-1:0] next_addr,
    output logic [ADDR_W-1:0] hdr_addr,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              clear,
    output logic              ld_freq,
    output logic              ld_repr,
    output logic              ld_mbox,
    output logic              ld_stats,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [2:0]        err_code,
    output logic [CNT_W-1:0]  rec_count
);
    walk_state_e       state_q;
    logic [ADDR_W-1:0] cur_q;
    logic [ADDR_W-1:0] resume_q;
    logic              first_q;
    logic              is_repr_q;
    logic              done_q;
    logic              err_q;
    walk_err_e         code_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              zero_list;
    logic              base_ok;

    assign zero_list = first_q && (rd_data == 32'd0);
    assign base_ok   = {1'b0, base_addr} < (ADDR_W+1)'(MEM_WORDS);
    assign busy      = (state_q != ST_IDLE);
    assign hdr_addr  = cur_q;
    assign done      = done_q;
    assign err       = err_q;
    assign err_code  = code_q;
    assign rec_count = cnt_q;

    // Read requests and capability load strobes for the current state.
    always_comb begin
        rd_en    = 1'b0;
        rd_addr  = base_addr;
        clear    = 1'b0;
        ld_freq  = 1'b0;
        ld_repr  = 1'b0;
        ld_mbox  = 1'b0;
        ld_stats = 1'b0;
        case (state_q)
            ST_IDLE: begin
                clear = start;
                rd_en = start && base_ok;
            end
            ST_HDR: begin
                if (!zero_list) begin
                    case (act)
                        ACT_SKIP:  begin rd_en = 1'b1; rd_addr = next_addr; end
                        ACT_MBOX:  begin rd_en = 1'b1; rd_addr = next_addr; ld_mbox = 1'b1; end
                        ACT_STATS: begin rd_en = 1'b1; rd_addr = next_addr; ld_stats = 1'b1; end
                        ACT_FREQ, ACT_REPR: begin rd_en = 1'b1; rd_addr = val_addr; end
                        default: ;
                    endcase
                end
            end
            ST_VAL: begin
                rd_en   = 1'b1;
                rd_addr = resume_q;
                ld_freq = !is_repr_q;
                ld_repr = is_repr_q;
            end
            default: ;
        endcase
    end

    // State, position, completion flags and record count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cur_q     <= '0;
            resume_q  <= '0;
            first_q   <= 1'b0;
            is_repr_q <= 1'b0;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
            code_q    <= ERR_NONE;
            cnt_q     <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        done_q <= 1'b0;
                        err_q  <= 1'b0;
                        code_q <= ERR_NONE;
                        cnt_q  <= '0;
                        if (!base_ok) begin
                            done_q <= 1'b1;
                            err_q  <= 1'b1;
                            code_q <= ERR_OVERRUN;
                        end else begin
                            state_q <= ST_HDR;
                            cur_q   <= base_addr;
                            first_q <= 1'b1;
                        end
                    end
                end
                ST_HDR: begin
                    first_q <= 1'b0;
                    if (zero_list) begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        case (act)
                            ACT_FAIL: begin
                                done_q  <= 1'b1;
                                err_q   <= 1'b1;
                                code_q  <= fail_code;
                                state_q <= ST_IDLE;
                            end
                            ACT_END: begin
                                cnt_q   <= cnt_q + 1'b1;
                                done_q  <= 1'b1;
                                state_q <= ST_IDLE;
                            end
                            ACT_FREQ, ACT_REPR: begin
                                cnt_q     <= cnt_q + 1'b1;
                                resume_q  <= next_addr;
                                is_repr_q <= (act == ACT_REPR);
                                state_q   <= ST_VAL;
                            end
                            default: begin
                                cnt_q <= cnt_q + 1'b1;
                                cur_q <= next_addr;
                            end
                        endcase
                    end
                end
                ST_VAL: begin
                    cur_q   <= resume_q;
                    state_q <= ST_HDR;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_RD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> ({1'b0, rd_addr} < (ADDR_W+1)'(MEM_WORDS))); // R11

    AST_DONE_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (state_q == ST_IDLE)); // R3

    AST_FAIL_ENDS_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> (done_q && code_q != ERR_NONE && !busy)); // R4

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1))); // R12

    AST_WALK_START_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start && base_ok) |-> (rd_en && rd_addr == base_addr)); // R1

endmodule

// File: rtl/caprec_walker.sv
// Capability record list walker, top level.
// Connects the header decoder, the walk sequencer and the capability bank.
// Assumes: an external memory with a one-cycle synchronous read port;
// MEM_WORDS no larger than 16384 so byte offsets fit in 16 bits.
module caprec_walker
    import caprec_pkg::*;
#(
    parameter int          MEM_WORDS    = 1024,
    parameter logic [15:0] MBOX_DEF_OFF = 16'h1800,
    parameter logic [15:0] MBOX_DEF_LEN = 16'h01F8,
    localparam int         ADDR_W       = (MEM_WORDS > 1) ? $clog2(MEM_WORDS) : 1,
    localparam int         CNT_W        = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [31:0]       rd_data,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [2:0]        err_code,
    output logic [31:0]       freq_mhz,
    output logic [15:0]       mbox_off,
    output logic [15:0]       mbox_len,
    output logic [31:0]       repr_cap,
    output logic [15:0]       stats_off,
    output logic [15:0]       stats_cnt,
    output logic [CNT_W-1:0]  rec_count
);
    rec_act_e          act;
    walk_err_e         fail_code;
    logic [ADDR_W-1:0] hdr_addr;
    logic [ADDR_W-1:0] val_addr;
    logic [ADDR_W-1:0] next_addr;
    logic [15:0]       val_len;
    logic [15:0]       stat_cnt;
    logic [15:0]       area_off;
    logic              clear;
    logic              ld_freq;
    logic              ld_repr;
    logic              ld_mbox;
    logic              ld_stats;

    assign area_off = 16'({val_addr, 2'b00});

    caprec_hdr_decode #(
        .MEM_WORDS (MEM_WORDS),
        .ADDR_W    (ADDR_W)
    ) u_decode (
        .hdr_word  (rd_data),
        .hdr_addr  (hdr_addr),
        .act       (act),
        .fail_code (fail_code),
        .val_addr  (val_addr),
        .next_addr (next_addr),
        .val_len   (val_len),
        .stat_cnt  (stat_cnt)
    );

    caprec_walk_ctrl #(
        .MEM_WORDS (MEM_WORDS),
        .ADDR_W    (ADDR_W),
        .CNT_W     (CNT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .base_addr (base_addr),
        .rd_data   (rd_data),
        .act       (act),
        .fail_code (fail_code),
        .val_addr  (val_addr),
        .next_addr (next_addr),
        .hdr_addr  (hdr_addr),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .clear     (clear),
        .ld_freq   (ld_freq),
        .ld_repr   (ld_repr),
        .ld_mbox   (ld_mbox),
        .ld_stats  (ld_stats),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .err_code  (err_code),
        .rec_count (rec_count)
    );

    caprec_cap_bank #(
        .MBOX_DEF_OFF (MBOX_DEF_OFF),
        .MBOX_DEF_LEN (MBOX_DEF_LEN)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .ld_freq   (ld_freq),
        .ld_repr   (ld_repr),
        .ld_mbox   (ld_mbox),
        .ld_stats  (ld_stats),
        .val_word  (rd_data),
        .area_off  (area_off),
        .area_len  (val_len),
        .area_cnt  (stat_cnt),
        .freq_mhz  (freq_mhz),
        .repr_cap  (repr_cap),
        .mbox_off  (mbox_off),
        .mbox_len  (mbox_len),
        .stats_off (stats_off),
        .stats_cnt (stats_cnt)
    );

endmodule

// File: tb/tb_caprec_walker.sv
// Directed bench for the capability record walker: one task per scenario.
module tb_caprec_walker;
    localparam int WORDS = 64;
    localparam int AW    = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic [31:0]   rd_data = '0;
    logic          busy, done, err;
    logic [2:0]    err_code;
    logic [31:0]   freq_mhz, repr_cap;
    logic [15:0]   mbox_off, mbox_len, stats_off, stats_cnt;
    logic [AW:0]   rec_count;

    logic [31:0] mem [WORDS];
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    caprec_walker #(.MEM_WORDS(WORDS)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .done(done), .err(err), .err_code(err_code),
        .freq_mhz(freq_mhz), .mbox_off(mbox_off), .mbox_len(mbox_len),
        .repr_cap(repr_cap), .stats_off(stats_off), .stats_cnt(stats_cnt),
        .rec_count(rec_count)
    );

    // Memory model with one cycle of read latency.
    always_ff @(posedge clk) begin
        if (rd_en) rd_data <= mem[rd_addr];
    end

    function automatic logic [31:0] hdr(input logic mand, input int kind, input int len);
        return {mand, kind[14:0], len[15:0]};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
        end
    endtask

    task automatic kick(input logic [AW-1:0] b);
        @(negedge clk);
        start = 1'b1;
        base_addr = b;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
        end
        check(req, "walk completes", {31'd0, done}, 32'd1);
    endtask

    task automatic t_reset_state;
        check("R2", "done after reset", {31'd0, done}, 32'd0);
        check("R2", "busy after reset", {31'd0, busy}, 32'd0);
        check("R2", "mailbox offset default", {16'd0, mbox_off}, 32'h1800);
        check("R2", "mailbox length default", {16'd0, mbox_len}, 32'h01F8);
    endtask

    task automatic t_full_list;
        @(negedge clk);
        start = 1'b1;
        base_addr = 6'd4;
        #1;
        check("R1", "read request on start", {31'd0, rd_en}, 32'd1);
        check("R1", "read address is base", {26'd0, rd_addr}, 32'd4);
        @(negedge clk);
        start = 1'b0;
        check("R1", "busy after start", {31'd0, busy}, 32'd1);
        wait_done("R3");
        check("R3", "no error at end marker", {31'd0, err}, 32'd0);
        check("R3", "record count", {25'd0, rec_count}, 32'd7);
        check("R7", "frequency word", freq_mhz, 32'd250);
        check("R7", "representor word", repr_cap, 32'hABCD_1234);
        check("R8", "mailbox offset", {16'd0, mbox_off}, 32'd32);
        check("R8", "mailbox length", {16'd0, mbox_len}, 32'd8);
        check("R9", "statistics offset", {16'd0, stats_off}, 32'd44);
        check("R9", "statistics count floor", {16'd0, stats_cnt}, 32'd3);
        check("R5", "unknown optional record skipped", {29'd0, err_code}, 32'd0);
        check("R6", "padding skipped", {31'd0, err}, 32'd0);
    endtask

    task automatic t_zero_base;
        kick(6'd0);
        wait_done("R2");
        check("R2", "empty list no error", {31'd0, err}, 32'd0);
        check("R2", "empty list count", {25'd0, rec_count}, 32'd0);
        check("R2", "frequency back to default", freq_mhz, 32'd0);
        check("R2", "mailbox offset back to default", {16'd0, mbox_off}, 32'h1800);
        check("R2", "statistics count back to default", {16'd0, stats_cnt}, 32'd0);
    endtask

    task automatic t_bad_type;
        kick(6'd28);
        wait_done("R4");
        check("R4", "error flag", {31'd0, err}, 32'd1);
        check("R4", "error code", {29'd0, err_code}, 32'd1);
        check("R4", "records before failure", {25'd0, rec_count}, 32'd1);
    endtask

    task automatic t_req_unknown;
        kick(6'd32);
        wait_done("R5");
        check("R5", "mandatory unknown code", {29'd0, err_code}, 32'd2);
        check("R5", "count", {25'd0, rec_count}, 32'd0);
    endtask

    task automatic t_misaligned;
        kick(6'd34);
        wait_done("R10");
        check("R10", "misaligned length code", {29'd0, err_code}, 32'd3);
    endtask

    task automatic t_overrun;
        kick(6'd36);
        wait_done("R11");
        check("R11", "overrun code", {29'd0, err_code}, 32'd4);
        check("R11", "count before overrun", {25'd0, rec_count}, 32'd1);
    endtask

    task automatic t_end_last_word;
        kick(6'd63);
        wait_done("R3");
        check("R3", "end in last word no error", {31'd0, err}, 32'd0);
        check("R3", "end in last word counted", {25'd0, rec_count}, 32'd1);
    endtask

    task automatic t_start_while_busy;
        kick(6'd4);
        @(negedge clk);
        start = 1'b1;
        base_addr = 6'd0;
        @(negedge clk);
        start = 1'b0;
        wait_done("R12");
        check("R12", "count unchanged by second start", {25'd0, rec_count}, 32'd7);
        check("R12", "frequency unchanged by second start", freq_mhz, 32'd250);
        check("R12", "no error", {31'd0, err}, 32'd0);
    endtask

    initial begin
        for (int i = 0; i < WORDS; i++) mem[i] = 32'd0;
        mem[4]  = hdr(1'b1, 3, 4);   mem[5] = 32'd250;
        mem[6]  = hdr(1'b0, 1, 0);
        mem[7]  = hdr(1'b0, 4, 8);   mem[8] = 32'h1111_1111; mem[9] = 32'h2222_2222;
        mem[10] = hdr(1'b0, 12, 36);
        for (int i = 11; i < 20; i++) mem[i] = 32'h5A5A_0000 + i;
        mem[20] = hdr(1'b0, 7, 4);   mem[21] = 32'hABCD_1234;
        mem[22] = hdr(1'b0, 9, 4);   mem[23] = 32'hFFFF_FFFF;
        mem[24] = hdr(1'b0, 2, 0);
        mem[28] = hdr(1'b0, 1, 4);   mem[29] = 32'hDEAD_BEEF;
        mem[30] = hdr(1'b0, 0, 4);
        mem[32] = hdr(1'b1, 9, 0);
        mem[34] = hdr(1'b0, 1, 6);
        mem[36] = hdr(1'b0, 1, 4);   mem[37] = 32'h0;
        mem[38] = hdr(1'b0, 1, 100);
        mem[63] = hdr(1'b0, 2, 0);

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_full_list();
        t_zero_base();
        t_bad_type();
        t_req_unknown();
        t_misaligned();
        t_overrun();
        t_end_last_word();
        t_start_while_busy();
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R1 watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule